// File: doc/BRIEF.md
# Layer Scroll Coordinate Generator

This block turns a screen position into a position inside one 512x512-pixel tile layer. It reads the layer's 32-bit scroll control word, adds the vertical scroll to the screen line and a horizontal scroll to the screen column, and wraps each sum on its own inside 512 pixels. With zero scroll the visible 496x384 window covers the top-left 62x48 tiles of the map. From the wrapped position it also derives the address of the 32-bit word that holds the layer's name-table entry. It passes on the layer enable bit so that later stages can skip the layer.

The horizontal offset comes from one of two sources. One is the scroll word itself, which then shifts every line by the same amount. The other is a per-line table in video memory. The table is used when the word's line-scroll select bit is set. In that case, at each line-start strobe the block issues a single 16-bit read from the table of the selected layer. It raises `busy` until the read returns, and holds the returned value for the rest of the line. Only the low nine bits of any offset matter, because the wrap discards the rest.

Top module: `layer_scroll_gen`

## Requirements
- R1: With `scroll_reg[15]` = 0, `map_x` equals (`scr_x` + `scroll_reg[9:0]`) mod 512, combinationally. Bit 9 of the field has no effect.
- R2: `map_y` equals (`scr_y` + `scroll_reg[24:16]`) mod 512, combinationally, independent of the horizontal source.
- R3: `layer_en` follows `scroll_reg[31]`.
- R4: A `line_start` seen at a clock edge with `scroll_reg[15]` = 1 and `busy` low makes `tbl_req` high for exactly the next cycle. `tbl_addr` is then 0xF6000 + 0x400 * `layer_sel` + 2 * `scr_y`, with the layer and line taken at the strobe (layer 0..3 gives tables at 0xF6000, 0xF6400, 0xF6800, 0xF6C00).
- R5: `busy` rises together with `tbl_req`, stays high while no `tbl_valid` has been seen, and is low in the cycle after the edge that samples `tbl_valid`.
- R6: With `scroll_reg[15]` = 1, `map_x` equals (`scr_x` + returned entry) mod 512, using only entry bits 8:0. The value is held until the next completed fetch, whatever `tbl_data` does in between. Before any fetch the held value is 0.
- R7: A `line_start` with `scroll_reg[15]` = 0 issues no request and leaves `busy` low.
- R8: `word_addr` equals (`map_y[8:3]` * 64 + `map_x[8:3]`) >> 1.
- R9: While `rst_n` is low at a clock edge, `busy` and `tbl_req` are low after that edge, and the held line offset returns to 0.
- R10: A `line_start` that arrives while `busy` is high is ignored: no new request is issued and the outstanding fetch completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | Start-of-line strobe, one cycle |
| layer_sel | input | 2 | Layer number, selects the line-scroll table |
| scroll_reg | input | 32 | Scroll control word: enable [31], vertical [24:16], line-scroll select [15], horizontal [9:0] |
| scr_x | input | 9 | Screen column, 0 to 495 |
| scr_y | input | 9 | Screen line, 0 to 383 |
| tbl_valid | input | 1 | Table read data valid |
| tbl_data | input | 16 | Table entry returned by memory |
| tbl_req | output | 1 | Table read request, one cycle |
| tbl_addr | output | 20 | Byte address of the requested table entry |
| busy | output | 1 | Table fetch outstanding |
| map_x | output | 9 | Wrapped tilemap column |
| map_y | output | 9 | Wrapped tilemap row |
| word_addr | output | 11 | Name-table word address |
| layer_en | output | 1 | Layer enable |

## Verification
Coordinates are driven with zero scroll, with mid-range scroll, and with sums just under and just over 512 on each axis. Together these separate a correct modulo-512 wrap from a missing wrap, a carry from one axis into the other, and a swapped axis. Setting bit 9 of the horizontal field and the upper bits of table entries shows whether the adder width is right. The fetch path is tried on every layer and on several lines, so that a wrong table base, stride or line scaling shows in `tbl_addr`. Changing `tbl_data` after a fetch completes, and sending strobes during a fetch or with the line-scroll select clear, separates a correctly held offset from one that follows the live bus.

// File: rtl/lsg_pkg.sv
// Package: shared constants for the layer scroll coordinate generator.
// Assumes a 512-pixel square tile layer of 8x8 tiles and a 1 MB video space.
package lsg_pkg;
    localparam int          MAP_BITS   = 9;       // log2 of layer size in pixels
    localparam int          TILE_SH    = 3;       // log2 of tile size in pixels
    localparam int          VADDR_W    = 20;      // video memory byte address width
    localparam logic [19:0] TBL_BASE   = 20'hF6000;
    localparam int          STRIDE_SH  = 10;      // table stride 0x400 bytes

    typedef enum logic {FETCH_IDLE, FETCH_WAIT} fetch_state_t;
endpackage

// File: rtl/lsg_axis_wrap.sv
// Module: modulo adder for one axis. Adds an offset to a position and keeps
// the low W bits, which is exactly a wrap inside a 2**W pixel space.
// Assumes both operands are already reduced to W bits.
module lsg_axis_wrap #(
    parameter int W = 9
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] off,
    output logic [W-1:0] wrapped
);
    // Sum truncated to W bits gives (pos + off) mod 2**W
    assign wrapped = pos + off;
endmodule

// File: rtl/lsg_line_fetch.sv
// Module: per-line horizontal offset fetch. On a line-start strobe in table
// mode it issues one read for the current line's entry, raises busy until the
// data returns, then holds the low bits of the entry until the next fetch.
// Assumes memory answers every request with exactly one tbl_valid pulse.
module lsg_line_fetch
    import lsg_pkg::*;
#(
    parameter int          LINE_W   = 9,
    parameter int          OFF_W    = 9,
    parameter int          LAYER_W  = 2,
    parameter int          ADDR_W   = 20,
    parameter logic [19:0] BASE     = 20'hF6000,
    parameter int          STR_SH   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               table_mode,
    input  logic [LAYER_W-1:0] layer,
    input  logic [LINE_W-1:0]  line_idx,
    input  logic               tbl_valid,
    input  logic [OFF_W-1:0]   tbl_off,
    output logic               tbl_req,
    output logic [ADDR_W-1:0]  tbl_addr,
    output logic               busy,
    output logic [OFF_W-1:0]   line_off
);
    fetch_state_t state_q;
    logic         launch;

    // A new fetch starts only from idle and only in table mode
    assign launch = line_start && table_mode && (state_q == FETCH_IDLE);
    assign busy   = (state_q == FETCH_WAIT);

    // Fetch sequencing: request pulse, wait for data, capture offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FETCH_IDLE;
            tbl_req  <= 1'b0;
            tbl_addr <= '0;
            line_off <= '0;
        end else begin
            tbl_req <= launch;
            if (launch) begin
                state_q  <= FETCH_WAIT;
                tbl_addr <= ADDR_W'(BASE)
                          + (ADDR_W'(layer) << STR_SH)
                          + (ADDR_W'(line_idx) << 1);
            end else if (state_q == FETCH_WAIT && tbl_valid) begin
                state_q  <= FETCH_IDLE;
                line_off <= tbl_off;
            end
        end
    end

    // R4: request lasts a single cycle
    assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_req |=> !tbl_req);
    // R5: a request is always accompanied by busy
    assert_busy_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_req |-> busy);
    // R7: a strobe in register mode never launches a fetch
    assert_no_fetch_reg_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !table_mode && !busy) |=> !tbl_req);
    // R10: strobes during an outstanding fetch are dropped
    assert_strobe_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && line_start) |=> !tbl_req);
    // R6: held offset only changes when returned data is accepted
    assert_offset_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && tbl_valid) |=> $stable(line_off));
    // R9: reset clears the fetch outputs
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (!busy && !tbl_req && line_off == '0));
endmodule

// File: rtl/lsg_addr_map.sv
// Module: name-table word address. Concatenates tile row and tile column into
// an entry index and drops its low bit, since two entries share one word.
// Assumes the caller passes the tile column already without its low bit.
module lsg_addr_map #(
    parameter int ROW_W = 6,
    parameter int COLH_W = 5
) (
    input  logic [ROW_W-1:0]        tile_row,
    input  logic [COLH_W-1:0]       tile_col_hi,
    output logic [ROW_W+COLH_W-1:0] word_addr
);
    // Index = row * 2**(COLH_W+1) + col; shifting right by one drops col[0]
    assign word_addr = {tile_row, tile_col_hi};
endmodule

// File: rtl/layer_scroll_gen.sv
// Module: scroll coordinate generator for one tile layer. Decodes the scroll
// word, picks the horizontal offset from the word or from the held per-line
// table value, wraps both axes and derives the name-table word address.
// Assumes scr_x/scr_y stay inside the visible window and the scroll word is
// stable across a line.
module layer_scroll_gen
    import lsg_pkg::*;
#(
    parameter int          MAP_W    = MAP_BITS,
    parameter int          TSH      = TILE_SH,
    parameter int          ADDR_W   = VADDR_W,
    parameter logic [19:0] TBL_BASE_P = TBL_BASE,
    parameter int          STRIDE_P = STRIDE_SH
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            line_start,
    input  logic [1:0]                      layer_sel,
    input  logic [31:0]                     scroll_reg,
    input  logic [MAP_W-1:0]                scr_x,
    input  logic [MAP_W-1:0]                scr_y,
    input  logic                            tbl_valid,
    input  logic [15:0]                     tbl_data,
    output logic                            tbl_req,
    output logic [ADDR_W-1:0]               tbl_addr,
    output logic                            busy,
    output logic [MAP_W-1:0]                map_x,
    output logic [MAP_W-1:0]                map_y,
    output logic [2*(MAP_W-TSH)-2:0]        word_addr,
    output logic                            layer_en
);
    localparam int TILE_IDX_W = MAP_W - TSH;

    logic             table_mode;
    logic [MAP_W-1:0] reg_hoff;
    logic [MAP_W-1:0] reg_voff;
    logic [MAP_W-1:0] line_off;
    logic [MAP_W-1:0] axis_pos [2];
    logic [MAP_W-1:0] axis_off [2];
    logic [MAP_W-1:0] axis_out [2];
    logic             unused_bits;

    // Field decode of the scroll control word
    assign layer_en   = scroll_reg[31];
    assign table_mode = scroll_reg[15];
    assign reg_voff   = scroll_reg[16 +: MAP_W];
    assign reg_hoff   = scroll_reg[MAP_W-1:0];
    assign unused_bits = ^{scroll_reg[30:16+MAP_W], scroll_reg[14:MAP_W],
                           tbl_data[15:MAP_W]};

    lsg_line_fetch #(
        .LINE_W (MAP_W),
        .OFF_W  (MAP_W),
        .LAYER_W(2),
        .ADDR_W (ADDR_W),
        .BASE   (TBL_BASE_P),
        .STR_SH (STRIDE_P)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .table_mode(table_mode),
        .layer     (layer_sel),
        .line_idx  (scr_y),
        .tbl_valid (tbl_valid),
        .tbl_off   (tbl_data[MAP_W-1:0]),
        .tbl_req   (tbl_req),
        .tbl_addr  (tbl_addr),
        .busy      (busy),
        .line_off  (line_off)
    );

    // Horizontal source select and per-axis operand routing
    always_comb begin
        axis_pos[0] = scr_x;
        axis_off[0] = table_mode ? line_off : reg_hoff;
        axis_pos[1] = scr_y;
        axis_off[1] = reg_voff;
    end

    for (genvar a = 0; a < 2; a++) begin : g_axis
        lsg_axis_wrap #(.W(MAP_W)) u_wrap (
            .pos    (axis_pos[a]),
            .off    (axis_off[a]),
            .wrapped(axis_out[a])
        );
    end

    assign map_x = axis_out[0];
    assign map_y = axis_out[1];

    lsg_addr_map #(
        .ROW_W (TILE_IDX_W),
        .COLH_W(TILE_IDX_W - 1)
    ) u_addr (
        .tile_row   (map_y[MAP_W-1:TSH]),
        .tile_col_hi(map_x[MAP_W-1:TSH+1]),
        .word_addr  (word_addr)
    );

    // R3: enable output tracks the control word's top bit
    assert_enable_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        layer_en == scroll_reg[31]);
endmodule

// File: tb/test_layer_scroll_gen.sv
module test_layer_scroll_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [1:0]  layer_sel = 2'd0;
    logic [31:0] scroll_reg = 32'd0;
    logic [8:0]  scr_x = 9'd0;
    logic [8:0]  scr_y = 9'd0;
    logic        tbl_valid = 1'b0;
    logic [15:0] tbl_data = 16'd0;
    logic        tbl_req;
    logic [19:0] tbl_addr;
    logic        busy;
    logic [8:0]  map_x;
    logic [8:0]  map_y;
    logic [10:0] word_addr;
    logic        layer_en;

    int checks = 0;
    int fails = 0;

    typedef struct {
        int    ex;
        int    ey;
        int    ew;
        int    een;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    layer_scroll_gen i_layer_scroll_gen (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .layer_sel(layer_sel),
        .scroll_reg(scroll_reg), .scr_x(scr_x), .scr_y(scr_y),
        .tbl_valid(tbl_valid), .tbl_data(tbl_data), .tbl_req(tbl_req),
        .tbl_addr(tbl_addr), .busy(busy), .map_x(map_x), .map_y(map_y),
        .word_addr(word_addr), .layer_en(layer_en)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_reg(int en, int vs, int tm, int hs);
        return (32'(en) << 31) | (32'(vs & 511) << 16) | (32'(tm) << 15) | 32'(hs & 1023);
    endfunction

    // Driver: set coordinates/word, push expected item computed from the rules
    task automatic drive(input int x, input int y, input logic [31:0] rw,
                         input int held, input string tag);
        exp_t e;
        int hs;
        @(negedge clk);
        scr_x = 9'(x);
        scr_y = 9'(y);
        scroll_reg = rw;
        hs = rw[15] ? (held & 511) : (int'(rw[9:0]) & 511);
        e.ex  = (x + hs) % 512;
        e.ey  = (y + int'(rw[24:16])) % 512;
        e.ew  = ((e.ey / 8) * 64 + (e.ex / 8)) / 2;
        e.een = int'(rw[31]);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare outputs shortly after each driving edge
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                chk(int'(map_x) == e.ex, {e.tag, " map_x"}, int'(map_x), e.ex);
                chk(int'(map_y) == e.ey, "R2 map_y", int'(map_y), e.ey);
                chk(int'(word_addr) == e.ew, "R8 word_addr", int'(word_addr), e.ew);
                chk(int'(layer_en) == e.een, "R3 layer_en", int'(layer_en), e.een);
            end
        end
    end

    // Full table fetch: strobe, check request, answer after a delay
    task automatic fetch(input int layer, input int line, input int data, input string tag);
        int ea;
        @(negedge clk);
        layer_sel = 2'(layer);
        scr_y = 9'(line);
        scroll_reg[15] = 1'b1;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        ea = 'hF6000 + layer * 'h400 + 2 * line;
        chk(tbl_req == 1'b1, {tag, " R4 req"}, int'(tbl_req), 1);
        chk(int'(tbl_addr) == ea, {tag, " R4 addr"}, int'(tbl_addr), ea);
        chk(busy == 1'b1, {tag, " R5 busy rise"}, int'(busy), 1);
        @(negedge clk);
        chk(tbl_req == 1'b0, {tag, " R4 single pulse"}, int'(tbl_req), 0);
        chk(busy == 1'b1, {tag, " R5 busy held"}, int'(busy), 1);
        @(negedge clk);
        tbl_valid = 1'b1;
        tbl_data = 16'(data);
        @(negedge clk);
        tbl_valid = 1'b0;
        tbl_data = 16'hFFFF;
        chk(busy == 1'b0, {tag, " R5 busy fall"}, int'(busy), 0);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9 busy in reset", int'(busy), 0);
        chk(tbl_req == 1'b0, "R9 req in reset", int'(tbl_req), 0);
        rst_n = 1'b1;
        // R9: held offset is zero after reset in table mode
        drive(100, 50, mk_reg(1, 0, 1, 0), 0, "R9");

        // R1/R2/R3/R8: register-driven scroll
        drive(0, 0, mk_reg(1, 0, 0, 0), 0, "R1 zero");
        drive(495, 383, mk_reg(0, 0, 0, 0), 0, "R1 corner");
        drive(200, 100, mk_reg(1, 37, 0, 123), 0, "R1 mid");
        drive(495, 383, mk_reg(1, 128, 0, 16), 0, "R1 wrap exact");
        drive(495, 383, mk_reg(1, 129, 0, 17), 0, "R1 wrap over");
        drive(10, 20, mk_reg(1, 511, 0, 511), 0, "R1 max");
        drive(10, 20, mk_reg(1, 5, 0, 512 + 7), 0, "R1 bit9 ignored");
        drive(255, 300, mk_reg(0, 211, 0, 256), 0, "R1 half");

        // R7: strobe in register mode does nothing
        @(negedge clk);
        scroll_reg = mk_reg(1, 0, 0, 0);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk(tbl_req == 1'b0, "R7 no request", int'(tbl_req), 0);
        chk(busy == 1'b0, "R7 no busy", int'(busy), 0);

        // R4/R5/R6: fetch on each layer, then use the held entry
        scroll_reg = mk_reg(1, 3, 1, 0);
        fetch(0, 0, 'h0005, "L0");
        drive(40, 0, mk_reg(1, 3, 1, 0), 'h0005, "R6 L0");
        fetch(1, 7, 'hFE10, "L1");
        drive(495, 7, mk_reg(1, 3, 1, 0), 'hFE10, "R6 upper bits ignored");
        fetch(2, 200, 'h01FF, "L2");
        drive(1, 200, mk_reg(1, 0, 1, 0), 'h01FF, "R6 wrap");
        fetch(3, 383, 'h0123, "L3");
        // R6: held despite bus changing
        drive(64, 383, mk_reg(1, 0, 1, 0), 'h0123, "R6 hold");
        @(negedge clk);
        tbl_data = 16'h0042;
        drive(64, 383, mk_reg(1, 0, 1, 0), 'h0123, "R6 hold bus");

        // R10: strobe during busy ignored
        @(negedge clk);
        layer_sel = 2'd1;
        scr_y = 9'd10;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk(tbl_req == 1'b1, "R10 first req", int'(tbl_req), 1);
        layer_sel = 2'd2;
        scr_y = 9'd99;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk(tbl_req == 1'b0, "R10 second strobe dropped", int'(tbl_req), 0);
        chk(busy == 1'b1, "R10 still busy", int'(busy), 1);
        chk(int'(tbl_addr) == 'hF6414, "R10 addr kept", int'(tbl_addr), 'hF6414);
        tbl_valid = 1'b1;
        tbl_data = 16'h0030;
        @(negedge clk);
        tbl_valid = 1'b0;
        chk(busy == 1'b0, "R10 completes", int'(busy), 0);
        drive(0, 10, mk_reg(1, 0, 1, 0), 'h0030, "R10 offset");

        // R9: reset clears held offset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(9, 9, mk_reg(1, 0, 1, 0), 0, "R9 cleared");

        repeat (3) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule